// File: doc/BRIEF.md
# Block Address Mapping Array

This block maps large, naturally aligned regions of a 32-bit effective address space straight onto 32-bit physical addresses, without going through paged translation. It holds two independent tables of the same shape. One serves instruction fetches and the other serves data loads and stores. Privileged code loads the tables through a register-access port. Each entry is a pair of 32-bit words: an upper word with the effective tag, the size mask and per-mode enables, and a lower word with the physical base and a write-protect bit.

For every lookup request the block reports, one cycle later, whether an entry matched or the access missed. A miss tells the surrounding memory unit to fall back to paged translation. On a match it returns the physical address. On the data side it also flags a protection fault when a store hits a write-protected region. Region size is set per entry and runs from 128 KB to 256 MB.

Top module: `blkx_xlate`

## Requirements
- R1: After reset every entry word reads zero, so no entry is enabled and every lookup misses. Every hit, miss, fault, address and read-data output is zero until the first request.
- R2: An entry matches when effective address bits 31..17 equal upper-word bits 31..17 at every position that the size mask does not release. Bits 31..28 are always compared. The result appears on the outputs in the cycle after the request.
- R3: On a hit the physical address takes lower-word bits 31..17 where the mask bit is 0 and the effective address bit where it is 1. Address bits 16..0 always pass through unchanged.
- R4: The size mask sits in upper-word bits 12..2. Mask bit k releases address bit 17+k. All zeros gives a 128 KB region and all ones a 256 MB region.
- R5: Upper-word bit 1 enables an entry for supervisor accesses and bit 0 enables it for user accesses. An entry whose bit for the current mode is 0 does not match.
- R6: Lower-word bit 0 marks a region write-protected. A data store that hits such an entry raises the fault output together with hit. A data load to the same region does not raise the fault.
- R7: The instruction table and the data table are separate. A write to one never changes the other's contents or lookups, and instruction lookups never raise a fault.
- R8: When several entries match, the lowest-numbered entry supplies the address and the write-protect bit.
- R9: Register reads and writes take effect only when the privileged flag is set. An unprivileged write changes nothing, and an unprivileged read returns zero. A privileged read returns the whole stored word one cycle later. The read data holds its value until the next read.
- R10: A register write becomes visible to lookups from the next cycle on. A lookup in the same cycle as the write still uses the old contents.
- R11: A request with no matching entry gives miss=1, hit=0, fault=0 and address 0. Without a request, hit and miss are both 0 and the address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Register access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_priv | input | 1 | Access is from privileged code |
| cfg_side | input | 1 | 0 = instruction table, 1 = data table |
| cfg_idx | input | 2 | Entry number |
| cfg_upper | input | 1 | 1 = upper word, 0 = lower word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| if_req | input | 1 | Instruction lookup request |
| if_ea | input | 32 | Instruction effective address |
| if_priv | input | 1 | Instruction fetch in supervisor mode |
| if_hit | output | 1 | Instruction lookup matched |
| if_miss | output | 1 | Instruction lookup found no entry |
| if_pa | output | 32 | Instruction physical address |
| dt_req | input | 1 | Data lookup request |
| dt_ea | input | 32 | Data effective address |
| dt_priv | input | 1 | Data access in supervisor mode |
| dt_store | input | 1 | Data access is a store |
| dt_hit | output | 1 | Data lookup matched |
| dt_miss | output | 1 | Data lookup found no entry |
| dt_pa | output | 32 | Data physical address |
| dt_fault | output | 1 | Store hit a write-protected region |

## Verification
The checker assumes that the inputs are known whenever reset is released. It also assumes that the store flag matters only together with a data request, and that the result properties compare the outputs against the request signals of the previous cycle. The stimulus drives every input on the falling clock edge and holds it through the rising edge. Outside a request it leaves address and flags at zero. Masks, enables and tags are written both with chosen values and with random ones, including unprivileged writes, overlapping entries and writes in the same cycle as a lookup, and a behavioural model predicts every output on every cycle.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

    localparam int AW        = 32;          // effective and physical address width
    localparam int OFS_W     = 17;          // low bits that always pass through
    localparam int TAG_W     = AW - OFS_W;  // compared upper bits
    localparam int MSK_W     = 11;          // releasable tag bits
    localparam int FIX_W     = TAG_W - MSK_W; // tag bits always compared

    // upper word layout
    localparam int UP_MSK_LSB = 2;
    localparam int UP_SUP     = 1;
    localparam int UP_USR     = 0;
    // lower word layout
    localparam int LO_RO      = 0;

    typedef struct packed {
        logic          hit;
        logic          miss;
        logic          fault;
        logic [AW-1:0] pa;
    } xres_t;

endpackage

// File: rtl/blkx_match.sv
module blkx_match
    import blkx_pkg::*;
(
    input  logic [TAG_W-1:0] ea_hi,
    input  logic             priv,
    input  logic [TAG_W-1:0] tag,
    input  logic [MSK_W-1:0] msk,
    input  logic             sup_ok,
    input  logic             usr_ok,
    input  logic [TAG_W-1:0] pbase,
    input  logic             ro_in,
    output logic             match,
    output logic [TAG_W-1:0] pa_hi,
    output logic             ro
);

    logic [TAG_W-1:0] care;
    logic [TAG_W-1:0] diff;
    logic             mode_ok;

    always_comb begin
        care    = ~{{FIX_W{1'b0}}, msk};
        diff    = (ea_hi ^ tag) & care;
        mode_ok = priv ? sup_ok : usr_ok;
        match   = (diff == '0) && mode_ok;
        pa_hi   = (pbase & care) | (ea_hi & ~care);
        ro      = ro_in;
    end

endmodule

// File: rtl/blkx_pick.sv
module blkx_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_vec,
    output logic [N-1:0] gnt,
    output logic         any
);

    // lowest set bit wins
    always_comb begin
        gnt = req_vec & (~req_vec + {{(N-1){1'b0}}, 1'b1});
        any = |req_vec;
    end

endmodule

// File: rtl/blkx_array.sv
module blkx_array
    import blkx_pkg::*;
#(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_hi,
    input  logic [AW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_hi,
    output logic [AW-1:0]    rd_word,
    input  logic             req,
    input  logic [AW-1:0]    ea,
    input  logic             priv,
    input  logic             store,
    output xres_t            res
);

    typedef struct packed {
        logic [N-1:0][AW-1:0] up;
        logic [N-1:0][AW-1:0] lo;
        xres_t                res;
    } st_t;

    st_t st_d, st_q;

    logic [N-1:0]            hit_vec;
    logic [N-1:0]            gnt;
    logic                    any;
    logic [N-1:0][TAG_W-1:0] pa_hi;
    logic [N-1:0]            ro_vec;
    logic [TAG_W-1:0]        sel_pa_hi;
    logic                    sel_ro;

    for (genvar i = 0; i < N; i++) begin : g_ent
        blkx_match u_match (
            .ea_hi  (ea[AW-1:OFS_W]),
            .priv   (priv),
            .tag    (st_q.up[i][AW-1:OFS_W]),
            .msk    (st_q.up[i][UP_MSK_LSB +: MSK_W]),
            .sup_ok (st_q.up[i][UP_SUP]),
            .usr_ok (st_q.up[i][UP_USR]),
            .pbase  (st_q.lo[i][AW-1:OFS_W]),
            .ro_in  (st_q.lo[i][LO_RO]),
            .match  (hit_vec[i]),
            .pa_hi  (pa_hi[i]),
            .ro     (ro_vec[i])
        );
    end

    blkx_pick #(.N(N)) u_pick (
        .req_vec (hit_vec),
        .gnt     (gnt),
        .any     (any)
    );

    always_comb begin
        sel_pa_hi = '0;
        sel_ro    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) begin
                sel_pa_hi = sel_pa_hi | pa_hi[i];
                sel_ro    = sel_ro | ro_vec[i];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_hi) st_d.up[wr_idx] = wr_data;
            else       st_d.lo[wr_idx] = wr_data;
        end
        st_d.res.hit   = req & any;
        st_d.res.miss  = req & ~any;
        st_d.res.fault = req & any & store & sel_ro;
        st_d.res.pa    = (req & any) ? {sel_pa_hi, ea[OFS_W-1:0]} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word = rd_hi ? st_q.up[rd_idx] : st_q.lo[rd_idx];
    assign res     = st_q.res;

endmodule

// File: rtl/blkx_xlate.sv
module blkx_xlate
    import blkx_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_wr,
    input  logic             cfg_priv,
    input  logic             cfg_side,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_upper,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cfg_rdata,
    input  logic             if_req,
    input  logic [AW-1:0]    if_ea,
    input  logic             if_priv,
    output logic             if_hit,
    output logic             if_miss,
    output logic [AW-1:0]    if_pa,
    input  logic             dt_req,
    input  logic [AW-1:0]    dt_ea,
    input  logic             dt_priv,
    input  logic             dt_store,
    output logic             dt_hit,
    output logic             dt_miss,
    output logic [AW-1:0]    dt_pa,
    output logic             dt_fault
);

    typedef struct packed {
        logic [AW-1:0] rdata;
    } top_t;

    top_t top_d, top_q;

    logic          wr_ok;
    logic          if_wr, dt_wr;
    logic [AW-1:0] if_word, dt_word;
    xres_t         if_res, dt_res;
    logic          if_fault_unused;

    assign wr_ok = cfg_en & cfg_wr & cfg_priv;
    assign if_wr = wr_ok & ~cfg_side;
    assign dt_wr = wr_ok &  cfg_side;

    blkx_array #(.N(N_ENT)) u_iarr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (if_wr),
        .wr_idx  (cfg_idx),
        .wr_hi   (cfg_upper),
        .wr_data (cfg_wdata),
        .rd_idx  (cfg_idx),
        .rd_hi   (cfg_upper),
        .rd_word (if_word),
        .req     (if_req),
        .ea      (if_ea),
        .priv    (if_priv),
        .store   (1'b0),
        .res     (if_res)
    );

    blkx_array #(.N(N_ENT)) u_darr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dt_wr),
        .wr_idx  (cfg_idx),
        .wr_hi   (cfg_upper),
        .wr_data (cfg_wdata),
        .rd_idx  (cfg_idx),
        .rd_hi   (cfg_upper),
        .rd_word (dt_word),
        .req     (dt_req),
        .ea      (dt_ea),
        .priv    (dt_priv),
        .store   (dt_store),
        .res     (dt_res)
    );

    always_comb begin
        top_d = top_q;
        if (cfg_en && !cfg_wr) begin
            if (!cfg_priv)     top_d.rdata = '0;
            else if (cfg_side) top_d.rdata = dt_word;
            else               top_d.rdata = if_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign cfg_rdata       = top_q.rdata;
    assign if_hit          = if_res.hit;
    assign if_miss         = if_res.miss;
    assign if_pa           = if_res.pa;
    assign if_fault_unused = if_res.fault;
    assign dt_hit          = dt_res.hit;
    assign dt_miss         = dt_res.miss;
    assign dt_pa           = dt_res.pa;
    assign dt_fault        = dt_res.fault;

endmodule

// File: rtl/blkx_xlate_chk.sv
module blkx_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_en,
    input logic        cfg_wr,
    input logic        cfg_priv,
    input logic [31:0] cfg_rdata,
    input logic        if_req,
    input logic        if_hit,
    input logic        if_miss,
    input logic [31:0] if_pa,
    input logic        if_fault,
    input logic        dt_req,
    input logic [31:0] dt_ea,
    input logic        dt_store,
    input logic        dt_hit,
    input logic        dt_miss,
    input logic [31:0] dt_pa,
    input logic        dt_fault
);

    // R2 / R11: a request yields exactly one of hit or miss in the next cycle
    p_if_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        if_req |=> (if_hit ^ if_miss));
    p_dt_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dt_req |=> (dt_hit ^ dt_miss));

    // R11: idle cycles give quiet outputs
    p_dt_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dt_req |=> (!dt_hit && !dt_miss && !dt_fault && dt_pa == '0));
    p_if_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !if_req |=> (!if_hit && !if_miss && if_pa == '0));

    // R11: a miss carries address zero
    p_miss_pa_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dt_miss |-> (dt_pa == '0 && !dt_fault));

    // R3: low offset bits pass through on a hit
    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dt_req |=> (dt_miss || dt_pa[16:0] == $past(dt_ea[16:0])));

    // R6: a fault needs a hit from a store
    p_fault_store_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dt_req && !dt_store |=> !dt_fault);
    p_fault_with_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dt_fault |-> dt_hit);

    // R7: instruction lookups never fault
    p_if_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !if_fault);

    // R9: unprivileged reads return zero, read data holds between reads
    p_unpriv_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cfg_wr && !cfg_priv) |=> (cfg_rdata == '0));
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && !cfg_wr) |=> $stable(cfg_rdata));

endmodule

bind blkx_xlate blkx_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_wr    (cfg_wr),
    .cfg_priv  (cfg_priv),
    .cfg_rdata (cfg_rdata),
    .if_req    (if_req),
    .if_hit    (if_hit),
    .if_miss   (if_miss),
    .if_pa     (if_pa),
    .if_fault  (if_fault_unused),
    .dt_req    (dt_req),
    .dt_ea     (dt_ea),
    .dt_store  (dt_store),
    .dt_hit    (dt_hit),
    .dt_miss   (dt_miss),
    .dt_pa     (dt_pa),
    .dt_fault  (dt_fault)
);

// File: tb/tb_blkx_xlate.sv
`timescale 1ns/1ps
module tb_blkx_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 0, cfg_wr = 0, cfg_priv = 0, cfg_side = 0, cfg_upper = 0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        if_req = 0, if_priv = 0;
    logic [31:0] if_ea = '0;
    logic        if_hit, if_miss;
    logic [31:0] if_pa;
    logic        dt_req = 0, dt_priv = 0, dt_store = 0;
    logic [31:0] dt_ea = '0;
    logic        dt_hit, dt_miss, dt_fault;
    logic [31:0] dt_pa;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    bit    done = 0;

    // behavioural model: [side][entry], side 0 = instruction, 1 = data
    logic [31:0] mu [2][4];
    logic [31:0] ml [2][4];
    logic [31:0] m_rd = '0;

    always #10 clk = ~clk;   // 50 MHz

    blkx_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_priv(cfg_priv), .cfg_side(cfg_side),
        .cfg_idx(cfg_idx), .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .if_req(if_req), .if_ea(if_ea), .if_priv(if_priv),
        .if_hit(if_hit), .if_miss(if_miss), .if_pa(if_pa),
        .dt_req(dt_req), .dt_ea(dt_ea), .dt_priv(dt_priv), .dt_store(dt_store),
        .dt_hit(dt_hit), .dt_miss(dt_miss), .dt_pa(dt_pa), .dt_fault(dt_fault)
    );

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    // size mask bit k sits at upper bit k+2 and releases address bit k+17
    function automatic void mlook(int side, logic [31:0] ea, logic priv, logic store,
                                  output logic hit, output logic [31:0] pa, output logic flt);
        hit = 0; pa = '0; flt = 0;
        for (int e = 0; e < 4; e++) begin
            logic        same;
            logic        en;
            same = 1;
            en   = priv ? mu[side][e][1] : mu[side][e][0];
            for (int b = 17; b < 32; b++) begin
                if (b >= 28 || !mu[side][e][b-15])
                    if (ea[b] !== mu[side][e][b]) same = 0;
            end
            if (en && same && !hit) begin
                hit = 1;
                for (int b = 0; b < 32; b++)
                    pa[b] = (b < 17 || (b < 28 && mu[side][e][b-15])) ? ea[b] : ml[side][e][b];
                flt = (side == 1) && store && ml[side][e][0];
            end
        end
    endfunction

    task automatic cyc();
        logic        ih, dh, dfl, ifl;
        logic [31:0] ip, dp;
        logic        eih, eim, edh, edm, edf;
        logic [31:0] eip, edp;
        ih = 0; ip = '0; ifl = 0; dh = 0; dp = '0; dfl = 0;
        if (if_req) mlook(0, if_ea, if_priv, 1'b0, ih, ip, ifl);
        if (dt_req) mlook(1, dt_ea, dt_priv, dt_store, dh, dp, dfl);
        eih = ih; eim = if_req && !ih; eip = ip;
        edh = dh; edm = dt_req && !dh; edp = dp; edf = dfl;
        if (cfg_en && !cfg_wr)
            m_rd = !cfg_priv ? '0 : (cfg_upper ? mu[cfg_side][cfg_idx] : ml[cfg_side][cfg_idx]);
        if (cfg_en && cfg_wr && cfg_priv) begin
            if (cfg_upper) mu[cfg_side][cfg_idx] = cfg_wdata;
            else           ml[cfg_side][cfg_idx] = cfg_wdata;
        end
        @(posedge clk);
        @(negedge clk);
        chk("if_hit",    {31'b0, if_hit},   {31'b0, eih});
        chk("if_miss",   {31'b0, if_miss},  {31'b0, eim});
        chk("if_pa",     if_pa,             eip);
        chk("dt_hit",    {31'b0, dt_hit},   {31'b0, edh});
        chk("dt_miss",   {31'b0, dt_miss},  {31'b0, edm});
        chk("dt_pa",     dt_pa,             edp);
        chk("dt_fault",  {31'b0, dt_fault}, {31'b0, edf});
        chk("cfg_rdata", cfg_rdata,         m_rd);
    endtask

    task automatic idle();
        cfg_en = 0; cfg_wr = 0; cfg_priv = 0; cfg_side = 0; cfg_idx = '0; cfg_upper = 0; cfg_wdata = '0;
        if_req = 0; if_ea = '0; if_priv = 0;
        dt_req = 0; dt_ea = '0; dt_priv = 0; dt_store = 0;
    endtask

    task automatic put(logic side, logic [1:0] idx, logic upper, logic [31:0] data, logic priv);
        cfg_en = 1; cfg_wr = 1; cfg_side = side; cfg_idx = idx; cfg_upper = upper;
        cfg_wdata = data; cfg_priv = priv;
    endtask

    task automatic get(logic side, logic [1:0] idx, logic upper, logic priv);
        cfg_en = 1; cfg_wr = 0; cfg_side = side; cfg_idx = idx; cfg_upper = upper;
        cfg_wdata = '0; cfg_priv = priv;
    endtask

    task automatic ilook(logic [31:0] ea, logic priv);
        if_req = 1; if_ea = ea; if_priv = priv;
    endtask

    task automatic dlook(logic [31:0] ea, logic priv, logic store);
        dt_req = 1; dt_ea = ea; dt_priv = priv; dt_store = store;
    endtask

    task automatic wr_cyc(logic side, logic [1:0] idx, logic upper, logic [31:0] data);
        idle(); put(side, idx, upper, data, 1'b1); cyc(); idle();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 4; e++) begin mu[s][e] = '0; ml[s][e] = '0; end
        idle();
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        cur_tag = "R1";
        chk("reset if_hit",  {31'b0, if_hit},   32'h0);
        chk("reset dt_miss", {31'b0, dt_miss},  32'h0);
        chk("reset dt_pa",   dt_pa,             32'h0);
        chk("reset rdata",   cfg_rdata,         32'h0);
        rst_n = 1;
        @(negedge clk);
        ilook(32'h0000_0000, 1); dlook(32'h1001_2345, 1, 0); cyc(); idle();
        get(1, 2'd3, 1, 1); cyc(); idle();

        // R10: write in the same cycle as a lookup uses the old contents
        cur_tag = "R10";
        put(1, 2'd0, 1, 32'h1000_0003, 1); dlook(32'h1001_2345, 1, 0); cyc(); idle();
        put(1, 2'd0, 0, 32'h8000_0000, 1); dlook(32'h1001_2345, 1, 0); cyc(); idle();
        dlook(32'h1001_2345, 1, 0); cyc(); idle();

        // R2: 128 KB region, bit 17 outside the region misses
        cur_tag = "R2";
        dlook(32'h1002_0000, 0, 0); cyc(); idle();
        dlook(32'h1001_FFFF, 0, 0); cyc(); idle();

        // R9: readback, unprivileged write ignored, unprivileged read zero
        cur_tag = "R9";
        get(1, 2'd0, 1, 1); cyc(); idle();
        get(1, 2'd0, 0, 1); cyc(); idle();
        put(1, 2'd1, 0, 32'hDEAD_0000, 0); cyc(); idle();
        get(1, 2'd1, 0, 1); cyc(); idle();
        get(1, 2'd0, 1, 0); cyc(); idle();
        cyc();

        // R4 / R3: 256 MB and 2 MB regions
        cur_tag = "R4";
        wr_cyc(1, 2'd1, 1, 32'h2000_1FFF);
        wr_cyc(1, 2'd1, 0, 32'h5000_0000);
        dlook(32'h2ABC_DEF1, 1, 0); cyc(); idle();
        dlook(32'h3000_0000, 1, 0); cyc(); idle();
        cur_tag = "R3";
        wr_cyc(1, 2'd2, 1, 32'h4060_003D);
        wr_cyc(1, 2'd2, 0, 32'h9000_0000);
        dlook(32'h407F_FFFF, 0, 0); cyc(); idle();
        dlook(32'h4080_0000, 0, 0); cyc(); idle();

        // R5: entry 2 is user-only
        cur_tag = "R5";
        dlook(32'h4060_0000, 1, 0); cyc(); idle();
        dlook(32'h4060_0000, 0, 1); cyc(); idle();

        // R6: write-protected supervisor region
        cur_tag = "R6";
        wr_cyc(1, 2'd3, 1, 32'h6000_0002);
        wr_cyc(1, 2'd3, 0, 32'h7000_0001);
        dlook(32'h6000_1234, 1, 1); cyc(); idle();
        dlook(32'h6000_1234, 1, 0); cyc(); idle();
        dlook(32'h6000_1234, 0, 1); cyc(); idle();

        // R8: overlap, lowest entry wins
        cur_tag = "R8";
        wr_cyc(1, 2'd3, 1, 32'h1000_0003);
        dlook(32'h1001_2345, 1, 1); cyc(); idle();
        wr_cyc(1, 2'd0, 1, 32'h0000_0000);
        dlook(32'h1001_2345, 1, 1); cyc(); idle();

        // R7: instruction table is separate
        cur_tag = "R7";
        ilook(32'h1001_2345, 1); cyc(); idle();
        wr_cyc(0, 2'd2, 1, 32'h1000_0003);
        wr_cyc(0, 2'd2, 0, 32'hA000_0001);
        ilook(32'h1001_2345, 1); dlook(32'h407F_FFFF, 0, 0); cyc(); idle();
        get(1, 2'd2, 0, 1); cyc(); idle();
        get(0, 2'd2, 0, 1); cyc(); idle();

        // R11: mixed random traffic with misses and idles
        cur_tag = "R11";
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  e;
            logic        s;
            logic [31:0] base;
            idle();
            e = 2'($urandom_range(0, 3));
            s = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) begin
                if ($urandom_range(0, 1) == 0) put(s, e, 1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 3) != 0));
                else                           get(s, e, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
            end
            if ($urandom_range(0, 2) != 0) begin
                base = ($urandom_range(0, 1) == 0) ? mu[0][e] : $urandom;
                ilook({base[31:17], 17'($urandom)} ^ (32'($urandom_range(0, 3)) << 17), 1'($urandom_range(0, 1)));
            end
            if ($urandom_range(0, 2) != 0) begin
                base = ($urandom_range(0, 1) == 0) ? mu[1][e] : $urandom;
                dlook({base[31:17], 17'($urandom)} ^ (32'($urandom_range(0, 3)) << 17),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end
            cyc();
        end
        idle();
        cyc();

        done = 1;
        summary();
        $finish;
    end

endmodule